// File: doc/BRIEF.md
# Complex-to-Real Quarter-Rate Converter

This block turns a stream of complex I/Q samples into a stream of real samples at the same rate. The input band must already be confined to between minus and plus one quarter of the sample rate. The block moves that band up by a quarter of the sample rate, which places it between zero and half the sample rate. It then keeps only one half of each rotated sample. The imaginary values that would be thrown away are never computed.

Each path, I and Q, has its own one-sample delay that can be switched in. For real output the I delay is enabled, and the Q half of the rotated sample is kept. The quarter-rate rotation uses a two-bit phase counter together with swaps and saturating negations, so the block needs no multipliers.

A single output-format flag is shared by every channel. When it is set, the block emits bare real values, packed two to a word, which halves the word rate. When it is clear, the block emits one complex word per sample, with the real value in the Q field.

Top module: `c2r_quarter_conv`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_data` is 0. The phase counter and both delay registers are zero.
- R2: The block does not decimate. In complex format, every cycle with `in_valid` high gives exactly one output word with `out_valid` high on the next cycle. A cycle with `in_valid` low gives no output and does not advance the phase.
- R3: With `dly_i_en` high, the I value used is the I value of the previous accepted sample, and it is 0 for the first sample after reset. With `dly_i_en` low, the current I is used.
- R4: The Q delay works the same way under `dly_q_en`, independently of the I setting.
- R5: Sample number n after reset, counting from 0, is multiplied by j^(n mod 4). (a,b) becomes (a,b), (-b,a), (-a,-b) and (b,-a) for phase 0, 1, 2 and 3.
- R6: With `keep_q` high, the imaginary part of the rotated sample is kept. With `keep_q` low, the real part is kept.
- R7: Negating the most negative value gives the most positive value.
- R8: With `real_only` low, `out_data[2W-1:W]` (the I field) is 0 and `out_data[W-1:0]` (the Q field) carries the kept value.
- R9: With `real_only` high, two successive kept values form one word. The first value goes in `out_data[W-1:0]` and the second in `out_data[2W-1:W]`. `out_valid` rises only on the second value.
- R10: Any cycle with `real_only` low discards a half-filled pair, so the next packing starts in the low half. `out_data` holds its last value while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | W | Signed I sample |
| in_q | input | W | Signed Q sample |
| dly_i_en | input | 1 | Switch in the one-sample I delay |
| dly_q_en | input | 1 | Switch in the one-sample Q delay |
| keep_q | input | 1 | Keep the imaginary half (1) or the real half (0) |
| real_only | input | 1 | Pack bare real values (1) or emit complex words (0) |
| out_valid | output | 1 | Output word strobe |
| out_data | output | 2W | Output word |

## Verification
Delay selection, rotation and half selection are all combinational in front of a single output register. The effect of an accepted sample therefore appears on `out_valid` and `out_data` one clock later, or on the second accepted sample when pairs are being packed. The bench drives each input on a falling edge and samples one time unit after the following rising edge. It compares the outputs against a model that is updated once per driven cycle. Idle cycles and format changes go through the same path, so the bench checks phase hold, pair discard and data hold at the cycle in which they take effect.

// File: rtl/c2r_pkg.sv
package c2r_pkg;
  typedef enum logic [1:0] {
    QP_0   = 2'd0,
    QP_90  = 2'd1,
    QP_180 = 2'd2,
    QP_270 = 2'd3
  } quad_phase_e;
endpackage

// File: rtl/c2r_delay.sv
module c2r_delay #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                en,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);
  logic signed [W-1:0] held_q, held_n;

  always_comb begin
    held_n = held_q;
    if (adv) held_n = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_n;
  end

  assign dout = en ? held_q : din;

  // R3/R4: the stored sample changes only on accepted input
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(held_q));
  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> held_q == $past(din));
endmodule

// File: rtl/c2r_rotator.sv
module c2r_rotator
  import c2r_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  input  logic                keep_q,
  output logic signed [W-1:0] dout
);
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  logic [1:0]          phase_q, phase_n;
  logic signed [W-1:0] src;
  logic                neg;

  always_comb begin
    phase_n = phase_q;
    if (adv) phase_n = phase_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_n;
  end

  always_comb begin
    src = a;
    neg = 1'b0;
    if (keep_q) begin
      unique case (phase_q)
        QP_0:    begin src = b; neg = 1'b0; end
        QP_90:   begin src = a; neg = 1'b0; end
        QP_180:  begin src = b; neg = 1'b1; end
        default: begin src = a; neg = 1'b1; end
      endcase
    end else begin
      unique case (phase_q)
        QP_0:    begin src = a; neg = 1'b0; end
        QP_90:   begin src = b; neg = 1'b1; end
        QP_180:  begin src = a; neg = 1'b1; end
        default: begin src = b; neg = 1'b0; end
      endcase
    end
  end

  always_comb begin
    dout = src;
    if (neg) dout = (src == MINV) ? MAXV : -src;
  end

  p_phase_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(phase_q));
  p_phase_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> phase_q == 2'($past(phase_q) + 2'd1));
  p_no_min_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    neg |-> dout != MINV);
endmodule

// File: rtl/c2r_formatter.sv
module c2r_formatter #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic signed [W-1:0] smp,
  input  logic                real_only,
  output logic                out_valid,
  output logic [2*W-1:0]      out_data
);
  localparam int DW = 2 * W;

  logic          vld_q, vld_n;
  logic [DW-1:0] data_q, data_n;
  logic [W-1:0]  lo_q, lo_n;
  logic          ptr_q, ptr_n;

  always_comb begin
    vld_n  = 1'b0;
    data_n = data_q;
    lo_n   = lo_q;
    ptr_n  = ptr_q;
    if (!real_only) begin
      ptr_n = 1'b0;
      if (smp_valid) begin
        vld_n  = 1'b1;
        data_n = {{W{1'b0}}, smp};
      end
    end else if (smp_valid) begin
      if (!ptr_q) begin
        lo_n  = smp;
        ptr_n = 1'b1;
      end else begin
        vld_n  = 1'b1;
        data_n = {smp, lo_q};
        ptr_n  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      lo_q   <= '0;
      ptr_q  <= 1'b0;
    end else begin
      vld_q  <= vld_n;
      data_q <= data_n;
      lo_q   <= lo_n;
      ptr_q  <= ptr_n;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;

  p_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !real_only) |=> out_valid);
  p_ifield_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !real_only) |=> out_data[DW-1:W] == '0);
  p_pair_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && real_only && !ptr_q) |=> !out_valid);
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !out_valid && $stable(out_data));
endmodule

// File: rtl/c2r_quarter_conv.sv
module c2r_quarter_conv #(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [W-1:0]     in_i,
  input  logic [W-1:0]     in_q,
  input  logic             dly_i_en,
  input  logic             dly_q_en,
  input  logic             keep_q,
  input  logic             real_only,
  output logic             out_valid,
  output logic [2*W-1:0]   out_data
);
  localparam int NPATH = 2;

  logic signed [W-1:0] raw  [NPATH];
  logic signed [W-1:0] used [NPATH];
  logic                den  [NPATH];
  logic signed [W-1:0] kept;

  assign raw[0] = in_i;
  assign raw[1] = in_q;
  assign den[0] = dly_i_en;
  assign den[1] = dly_q_en;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    c2r_delay #(.W(W)) u_dly (
      .clk  (clk),
      .rst_n(rst_n),
      .adv  (in_valid),
      .en   (den[p]),
      .din  (raw[p]),
      .dout (used[p])
    );
  end

  c2r_rotator #(.W(W)) u_rot (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (in_valid),
    .a     (used[0]),
    .b     (used[1]),
    .keep_q(keep_q),
    .dout  (kept)
  );

  c2r_formatter #(.W(W)) u_fmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(in_valid),
    .smp      (kept),
    .real_only(real_only),
    .out_valid(out_valid),
    .out_data (out_data)
  );
endmodule

// File: tb/tb_c2r_quarter_conv.sv
module tb_c2r_quarter_conv;
  localparam int W = 16;
  localparam int CLK_PERIOD = 10;
  localparam int MINI = -(1 << (W-1));
  localparam int MAXI = (1 << (W-1)) - 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid, dly_i_en, dly_q_en, keep_q, real_only;
  logic [W-1:0]     in_i, in_q;
  logic             out_valid;
  logic [2*W-1:0]   out_data;

  int checks = 0;
  int errors = 0;

  int            m_pi, m_pq, m_ph;
  bit            m_ptr;
  logic [W-1:0]  m_lo;
  bit            e_valid;
  logic [2*W-1:0] e_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  c2r_quarter_conv #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .dly_i_en(dly_i_en), .dly_q_en(dly_q_en), .keep_q(keep_q),
    .real_only(real_only), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic int clampv(int x);
    if (x > MAXI) return MAXI;
    if (x < MINI) return MINI;
    return x;
  endfunction

  // kept half of (a + jb) * j^k, saturated
  function automatic int ref_rot(int a, int b, int k, bit kq);
    int re, im;
    case (k)
      0: begin re = a;  im = b;  end
      1: begin re = -b; im = a;  end
      2: begin re = -a; im = -b; end
      default: begin re = b; im = -a; end
    endcase
    return clampv(kq ? im : re);
  endfunction

  task automatic check(string tag, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, int i, int q, bit di, bit dq, bit kq, bit ro,
                      string tag);
    int a, b, r;
    @(negedge clk);
    in_valid = v; in_i = W'(i); in_q = W'(q);
    dly_i_en = di; dly_q_en = dq; keep_q = kq; real_only = ro;
    e_valid = 1'b0;
    if (v) begin
      a = di ? m_pi : i;
      b = dq ? m_pq : q;
      r = ref_rot(a, b, m_ph, kq);
      m_pi = i; m_pq = q; m_ph = (m_ph + 1) % 4;
      if (!ro) begin
        e_valid = 1'b1; e_data = {{W{1'b0}}, W'(r)}; m_ptr = 1'b0;
      end else if (!m_ptr) begin
        m_lo = W'(r); m_ptr = 1'b1;
      end else begin
        e_valid = 1'b1; e_data = {W'(r), m_lo}; m_ptr = 1'b0;
      end
    end else if (!ro) begin
      m_ptr = 1'b0;
    end
    @(posedge clk); #1;
    check({tag, " valid"}, {{(2*W-1){1'b0}}, out_valid}, {{(2*W-1){1'b0}}, e_valid});
    check({tag, " data"}, out_data, e_data);
  endtask

  function automatic int sgn(logic [W-1:0] x);
    return int'($signed(x));
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_c2a1;
    void'($urandom(seed));
    rst_n = 1'b0; in_valid = 0; in_i = '0; in_q = '0;
    dly_i_en = 0; dly_q_en = 0; keep_q = 0; real_only = 0;
    m_pi = 0; m_pq = 0; m_ph = 0; m_ptr = 0; m_lo = '0;
    e_valid = 0; e_data = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", {{(2*W-1){1'b0}}, out_valid}, '0);
    check("R1 reset data", out_data, '0);
    @(negedge clk); rst_n = 1'b1;

    // R3: delayed I is zero for the first sample; R4 Q delay independent
    step(1, 100, 7, 1, 0, 0, 0, "R3 first delayed I");
    step(1, 200, 9, 1, 0, 0, 0, "R3 delayed I");
    step(1, 300, 11, 0, 1, 1, 0, "R4 delayed Q");
    step(1, 400, 13, 1, 1, 1, 0, "R4 both delayed");
    // R2: idle cycles hold the phase and emit nothing
    step(0, 5, 5, 0, 0, 1, 0, "R2 idle");
    step(0, 6, 6, 0, 0, 1, 0, "R2 idle");
    step(1, 500, -600, 0, 0, 1, 0, "R2 resume phase");
    // R7: saturating negation of the minimum, both halves
    for (int k = 0; k < 8; k++)
      step(1, MINI, MINI, 0, 0, k[2], 0, "R7 min negate");
    step(1, MAXI, MINI, 0, 0, 0, 0, "R7 mixed extremes");
    // R9 pairing, R10 discard of a half pair
    step(1, 11, 22, 1, 0, 1, 1, "R9 first half");
    step(1, 33, 44, 1, 0, 1, 1, "R9 pair out");
    step(1, 55, 66, 1, 0, 1, 1, "R9 first half again");
    step(0, 0, 0, 1, 0, 1, 1, "R10 hold while pairing");
    step(0, 0, 0, 1, 0, 1, 0, "R10 discard half pair");
    step(1, 77, 88, 1, 0, 1, 1, "R10 restart low half");
    step(1, 99, -99, 1, 0, 1, 1, "R9 pair after restart");
    // R5/R6/R8: complex tone through complex-to-real setting
    for (int n = 0; n < 64; n++) begin
      real ph;
      ph = 2.0 * 3.14159265 * n * 0.11;
      step(1, $rtoi(12000.0 * $cos(ph)), $rtoi(12000.0 * $sin(ph)),
           1, 0, 1, n >= 32, "R5 R6 R8 tone");
    end
    // random mix of flags and data
    for (int n = 0; n < 400; n++) begin
      int ri, rq;
      ri = sgn(W'($urandom));
      rq = sgn(W'($urandom));
      step(($urandom % 4) != 0, ri, rq, 1'($urandom), 1'($urandom),
           1'($urandom), ($urandom % 3) == 0, "R2 R5 R6 R9 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule